// File: doc/BRIEF.md
# Externally Clocked Four-Buffer Port

This block gives an outside bus master direct access to four internal byte buffers of 512 bytes each. The master selects a buffer with a 2-bit index and moves data with a write strobe and a read strobe. It drives the shared data lines only while an output-enable pin is raised. Every control pin is qualified by an active-low chip select. Each buffer is set to 8-bit or 16-bit transfers by its own configuration bit. A mode pin picks one of two strobe styles. In the clocked style, a strobe held high moves one item on each rising clock edge. In the edge style, each rising edge of a strobe moves exactly one item after a short synchroniser.

A packet-end pin closes the data written so far into the addressed buffer as a packet, even a short or empty one. The block reports that packet on a one-cycle notice carrying the buffer index and its length in bytes. There is no ready input on this notice: the consumer must take it in the cycle it appears.

The read path is show-ahead. The oldest byte of the addressed buffer sits on the low data lines before the read strobe. In 16-bit mode the next byte sits on the high lines. Back-pressure is given by the registered empty and full flags of the addressed buffer. A write that does not fit and a read of an empty buffer are dropped, and the buffer does not change.

Top module: `sfp_port`

## Requirements
- R1: `fifo_addr` picks the buffer that every write, read, packet end, the read data and both flags refer to; the other buffers are left untouched.
- R2: While `cs_n` is high, `wr_strb`, `rd_strb`, `oe` and `pkt_end` have no effect: no buffer changes, `data_oe` stays 0 and no packet notice appears.
- R3: With `async_mode`=0, each rising clock edge at which the strobe is high and `cs_n` is low moves one item.
- R4: With `async_mode`=1, each rising edge of a chip-selected strobe moves exactly one item, however long the strobe is held. The transfer takes effect at the third rising clock edge after the strobe rises. Data and address are sampled at that edge.
- R5: Bit i of `word_cfg` set makes buffer i 16-bit. A write stores `data_in[7:0]` and then `data_in[15:8]`. A read shows the oldest byte on `data_out[7:0]` and the next on `data_out[15:8]`, and removes both. With the bit clear, only `data_in[7:0]` is stored, `data_out[15:8]` reads 0 and a read removes one byte.
- R6: A buffer holds exactly 512 bytes. A 16-bit write that finds only one free byte is dropped whole.
- R7: `data_oe` is 1 only while `cs_n` is low and `oe` is high. Whenever `data_oe` is 0, `data_out` is all zeros.
- R8: A packet end on a buffer raises `pkt_valid` for one cycle after that edge. `pkt_fifo` carries the buffer index. `pkt_len` carries the bytes written to that buffer since its previous packet end, including any write at the same edge. A length of zero is allowed.
- R9: A write to a buffer without room and a read from an empty buffer are ignored.
- R10: `empty` and `full` are registered. After each rising edge they show the state of the buffer addressed at that edge, as it stood after the previous edge.
- R11: A 16-bit read from a buffer holding one byte returns that byte on the low lines with 0 on the high lines, and removes one byte.
- R12: After reset all buffers are empty, `empty`=1, `full`=0 and `pkt_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| async_mode | input | 1 | 0: strobes qualify clock edges; 1: strobe edges are transfers |
| word_cfg | input | 4 | Per-buffer width, 1 = 16-bit |
| cs_n | input | 1 | Active-low chip select |
| wr_strb | input | 1 | Write strobe, active high |
| rd_strb | input | 1 | Read strobe, active high |
| oe | input | 1 | Output enable, active high |
| pkt_end | input | 1 | Close a packet in the addressed buffer |
| fifo_addr | input | 2 | Buffer index |
| data_in | input | 16 | Write data |
| data_out | output | 16 | Show-ahead read data, zero when not driven |
| data_oe | output | 1 | High when the block drives the data lines |
| empty | output | 1 | Addressed buffer is empty |
| full | output | 1 | Addressed buffer is full |
| pkt_valid | output | 1 | One-cycle packet notice |
| pkt_fifo | output | 2 | Buffer index of the notice |
| pkt_len | output | 16 | Packet length in bytes |

## Verification
The clocked style is driven with held strobes, mixed read and write edges, and index changes between cycles. These separate per-edge counting and show which buffer a transfer lands in. The edge style is driven with strobes held for several cycles and with short gaps. This exposes double counting and wrong latency. A 16-bit buffer is run alongside an 8-bit one, including an odd leftover byte, to catch byte order and wrong removal counts. One buffer is filled to 512 bytes and another to 511 bytes before a 16-bit write, to find the exact boundary of the full flag and the dropped write.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
  localparam int BYTE_W = 8;
  localparam int BUS_W  = 2 * BYTE_W;

  // index of each control line inside the gated control vector
  typedef enum int {
    CTL_WR = 0,
    CTL_RD = 1,
    CTL_PE = 2
  } sfp_ctl_e;
  localparam int N_CTL = 3;
endpackage

// File: rtl/sfp_edge_sync.sv
module sfp_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic level_in,
  output logic rise
);
  logic s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= level_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign rise = s2 & ~s3;
endmodule

// File: rtl/sfp_buffer.sv
module sfp_buffer #(
  parameter int DEPTH = 512,
  parameter int LEN_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic                      rd_en,
  input  logic                      close_pkt,
  input  logic                      word_mode,
  input  logic [sfp_pkg::BUS_W-1:0] wr_data,
  output logic [sfp_pkg::BYTE_W-1:0] head_lo,
  output logic [sfp_pkg::BYTE_W-1:0] head_hi,
  output logic [$clog2(DEPTH):0]    fill,
  output logic [LEN_W-1:0]          len_now
);
  import sfp_pkg::*;

  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW:0]      DEPTH_X = (CW+1)'(DEPTH);
  localparam logic [LEN_W-1:0] LEN_MAX = '1;

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wp, rp;
  logic [CW-1:0]     cnt;
  logic [LEN_W-1:0]  pend;
  logic [CW-1:0]     wn, rn;
  logic              wr_ok, rd_ok;
  logic [LEN_W:0]    len_sum;

  assign wn    = word_mode ? CW'(2) : CW'(1);
  assign rn    = (word_mode && cnt >= CW'(2)) ? CW'(2) : CW'(1);
  assign wr_ok = wr_en && ({1'b0, cnt} + {1'b0, wn} <= DEPTH_X);
  assign rd_ok = rd_en && (cnt != '0);

  always_ff @(posedge clk) begin
    if (wr_ok) begin
      mem[wp] <= wr_data[BYTE_W-1:0];
      if (word_mode) mem[wp + AW'(1)] <= wr_data[BUS_W-1:BYTE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      cnt  <= '0;
      pend <= '0;
    end else begin
      if (wr_ok) wp <= wp + AW'(wn);
      if (rd_ok) rp <= rp + AW'(rn);
      cnt <= cnt + (wr_ok ? wn : '0) - (rd_ok ? rn : '0);
      if (close_pkt)  pend <= '0;
      else if (wr_ok) pend <= len_now;
    end
  end

  // saturating length of the open packet including this edge's write
  assign len_sum = {1'b0, pend} + (wr_ok ? (LEN_W+1)'(wn) : '0);
  assign len_now = len_sum[LEN_W] ? LEN_MAX : len_sum[LEN_W-1:0];

  assign head_lo = (cnt != '0)      ? mem[rp]           : '0;
  assign head_hi = (cnt >= CW'(2))  ? mem[rp + AW'(1)]  : '0;
  assign fill    = cnt;
endmodule

// File: rtl/sfp_port.sv
module sfp_port #(
  parameter int N_FIFO = 4,
  parameter int DEPTH  = 512,
  parameter int LEN_W  = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        async_mode,
  input  logic [N_FIFO-1:0]           word_cfg,
  input  logic                        cs_n,
  input  logic                        wr_strb,
  input  logic                        rd_strb,
  input  logic                        oe,
  input  logic                        pkt_end,
  input  logic [$clog2(N_FIFO)-1:0]   fifo_addr,
  input  logic [sfp_pkg::BUS_W-1:0]   data_in,
  output logic [sfp_pkg::BUS_W-1:0]   data_out,
  output logic                        data_oe,
  output logic                        empty,
  output logic                        full,
  output logic                        pkt_valid,
  output logic [$clog2(N_FIFO)-1:0]   pkt_fifo,
  output logic [LEN_W-1:0]            pkt_len
);
  import sfp_pkg::*;

  localparam int AW = $clog2(N_FIFO);
  localparam int CW = $clog2(DEPTH) + 1;

  logic              sel;
  logic [N_CTL-1:0]  ctl_lvl, ctl_rise, ctl_ev;

  logic [BYTE_W-1:0] head_lo [N_FIFO];
  logic [BYTE_W-1:0] head_hi [N_FIFO];
  logic [CW-1:0]     fill    [N_FIFO];
  logic [LEN_W-1:0]  len_now [N_FIFO];

  assign sel = ~cs_n;
  assign ctl_lvl[CTL_WR] = sel & wr_strb;
  assign ctl_lvl[CTL_RD] = sel & rd_strb;
  assign ctl_lvl[CTL_PE] = sel & pkt_end;

  generate
    for (genvar c = 0; c < N_CTL; c++) begin : g_ctl
      sfp_edge_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_in (ctl_lvl[c]),
        .rise     (ctl_rise[c])
      );
      assign ctl_ev[c] = async_mode ? ctl_rise[c] : ctl_lvl[c];
    end

    for (genvar i = 0; i < N_FIFO; i++) begin : g_buf
      logic hit;
      assign hit = (fifo_addr == AW'(i));
      sfp_buffer #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (hit & ctl_ev[CTL_WR]),
        .rd_en     (hit & ctl_ev[CTL_RD]),
        .close_pkt (hit & ctl_ev[CTL_PE]),
        .word_mode (word_cfg[i]),
        .wr_data   (data_in),
        .head_lo   (head_lo[i]),
        .head_hi   (head_hi[i]),
        .fill      (fill[i]),
        .len_now   (len_now[i])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty     <= 1'b1;
      full      <= 1'b0;
      pkt_valid <= 1'b0;
      pkt_fifo  <= '0;
      pkt_len   <= '0;
    end else begin
      empty     <= (fill[fifo_addr] == '0);
      full      <= (fill[fifo_addr] == CW'(DEPTH));
      pkt_valid <= ctl_ev[CTL_PE];
      if (ctl_ev[CTL_PE]) begin
        pkt_fifo <= fifo_addr;
        pkt_len  <= len_now[fifo_addr];
      end
    end
  end

  assign data_oe = sel & oe;

  always_comb begin
    data_out = '0;
    if (data_oe) begin
      data_out[BYTE_W-1:0] = head_lo[fifo_addr];
      if (word_cfg[fifo_addr]) data_out[BUS_W-1:BYTE_W] = head_hi[fifo_addr];
    end
  end
endmodule

// File: rtl/sfp_port_chk.sv
module sfp_port_chk #(
  parameter int N_FIFO = 4,
  parameter int LEN_W  = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      async_mode,
  input logic                      cs_n,
  input logic                      wr_strb,
  input logic                      rd_strb,
  input logic                      pkt_end,
  input logic [$clog2(N_FIFO)-1:0] fifo_addr,
  input logic [15:0]               data_out,
  input logic                      data_oe,
  input logic                      empty,
  input logic                      full,
  input logic                      pkt_valid
);
  // R7: undriven bus carries no data
  a_r7_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !data_oe |-> data_out == '0);

  // R10: flags never both set
  a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full));

  // R8 and R2: a clocked-style notice needs a selected packet end
  a_r8_notice_cause: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> ($past(async_mode) || $past(!cs_n && pkt_end)));

  // R3: a clocked write with no read leaves the buffer non-empty
  a_r3_write_clears_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (!async_mode && !cs_n && wr_strb && !rd_strb) |=> ##1
      (($past(fifo_addr, 2) == $past(fifo_addr)) -> !empty));
endmodule

bind sfp_port sfp_port_chk #(.N_FIFO(N_FIFO), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .async_mode(async_mode), .cs_n(cs_n),
  .wr_strb(wr_strb), .rd_strb(rd_strb), .pkt_end(pkt_end),
  .fifo_addr(fifo_addr), .data_out(data_out), .data_oe(data_oe),
  .empty(empty), .full(full), .pkt_valid(pkt_valid)
);

// File: tb/sfp_port_bench.sv
module sfp_port_bench;
  localparam int CLK_HALF = 5;
  localparam int DEPTH    = 512;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        async_mode = 1'b0;
  logic [3:0]  word_cfg = 4'b1010;
  logic        cs_n = 1'b1, wr_strb = 1'b0, rd_strb = 1'b0, oe = 1'b0, pkt_end = 1'b0;
  logic [1:0]  fifo_addr = 2'd0;
  logic [15:0] data_in = '0;
  logic [15:0] data_out;
  logic        data_oe, empty, full, pkt_valid;
  logic [1:0]  pkt_fifo;
  logic [15:0] pkt_len;

  always #CLK_HALF clk = ~clk;

  sfp_port u_sfp_port (
    .clk(clk), .rst_n(rst_n), .async_mode(async_mode), .word_cfg(word_cfg),
    .cs_n(cs_n), .wr_strb(wr_strb), .rd_strb(rd_strb), .oe(oe),
    .pkt_end(pkt_end), .fifo_addr(fifo_addr), .data_in(data_in),
    .data_out(data_out), .data_oe(data_oe), .empty(empty), .full(full),
    .pkt_valid(pkt_valid), .pkt_fifo(pkt_fifo), .pkt_len(pkt_len)
  );

  // ---------------- behavioural reference ----------------
  logic [7:0] q [4][$];
  int         pend [4];
  logic       e_empty, e_full, e_pv;
  logic [1:0] e_pf;
  int         e_pl;
  bit         sw [3], sr [3], sp [3];   // delay lines for the edge style

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin q[i].delete(); pend[i] = 0; end
      e_empty = 1; e_full = 0; e_pv = 0; e_pf = 0; e_pl = 0;
      for (int k = 0; k < 3; k++) begin sw[k] = 0; sr[k] = 0; sp[k] = 0; end
    end else begin
      bit lw, lr, lp, ew, er, ep, wok;
      int a, sz, wn;
      lw = !cs_n && wr_strb; lr = !cs_n && rd_strb; lp = !cs_n && pkt_end;
      if (async_mode) begin
        ew = sw[1] && !sw[2]; er = sr[1] && !sr[2]; ep = sp[1] && !sp[2];
      end else begin
        ew = lw; er = lr; ep = lp;
      end
      sw[2] = sw[1]; sw[1] = sw[0]; sw[0] = lw;
      sr[2] = sr[1]; sr[1] = sr[0]; sr[0] = lr;
      sp[2] = sp[1]; sp[1] = sp[0]; sp[0] = lp;
      a  = fifo_addr;
      sz = q[a].size();
      e_empty = (sz == 0);
      e_full  = (sz == DEPTH);
      wn  = word_cfg[a] ? 2 : 1;
      wok = ew && (sz + wn <= DEPTH);
      e_pv = ep;
      if (ep) begin
        e_pf = fifo_addr;
        e_pl = pend[a] + (wok ? wn : 0);
        if (e_pl > 65535) e_pl = 65535;
      end
      if (er && sz > 0) begin
        void'(q[a].pop_front());
        if (word_cfg[a] && sz >= 2) void'(q[a].pop_front());
      end
      if (wok) begin
        q[a].push_back(data_in[7:0]);
        if (word_cfg[a]) q[a].push_back(data_in[15:8]);
      end
      if (ep) pend[a] = 0;
      else if (wok) begin pend[a] = pend[a] + wn; if (pend[a] > 65535) pend[a] = 65535; end
    end
  end

  // ---------------- checking ----------------
  int    n_vec = 0, n_bad = 0;
  string scen = "R12";

  task automatic cmp(string tag, int act, int exp);
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s (%s) at %0t: got %h expected %h", tag, scen, $time, act, exp);
    end
  endtask

  task automatic tick();
    logic [15:0] x_out;
    logic        x_oe;
    int          a;
    @(posedge clk);
    @(negedge clk);
    a    = fifo_addr;
    x_oe = !cs_n && oe;
    x_out = '0;
    if (x_oe && q[a].size() > 0) begin
      x_out[7:0] = q[a][0];
      if (word_cfg[a] && q[a].size() >= 2) x_out[15:8] = q[a][1];
    end
    n_vec++;
    cmp("R7 data_oe", data_oe, x_oe);
    cmp("R5 data_out", data_out, x_out);
    cmp("R10 empty", empty, e_empty);
    cmp("R10 full", full, e_full);
    cmp("R8 pkt_valid", pkt_valid, e_pv);
    if (e_pv) begin
      cmp("R8 pkt_fifo", pkt_fifo, e_pf);
      cmp("R8 pkt_len", pkt_len, e_pl);
    end
  endtask

  task automatic idle(int n);
    cs_n = 1; wr_strb = 0; rd_strb = 0; oe = 0; pkt_end = 0;
    repeat (n) tick();
  endtask

  task automatic wr(int a, logic [15:0] d);
    cs_n = 0; oe = 0; rd_strb = 0; pkt_end = 0; wr_strb = 1; fifo_addr = 2'(a); data_in = d;
    tick();
    wr_strb = 0;
  endtask

  task automatic rd(int a);
    cs_n = 0; oe = 1; wr_strb = 0; pkt_end = 0; rd_strb = 1; fifo_addr = 2'(a);
    tick();
    rd_strb = 0;
  endtask

  task automatic peek(int a);
    cs_n = 0; oe = 1; wr_strb = 0; rd_strb = 0; pkt_end = 0; fifo_addr = 2'(a);
    tick();
  endtask

  task automatic close(int a);
    cs_n = 0; oe = 0; wr_strb = 0; rd_strb = 0; pkt_end = 1; fifo_addr = 2'(a);
    tick();
    pkt_end = 0;
  endtask

  bit done = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    // R12: reset state
    scen = "R12";
    repeat (3) tick();
    @(negedge clk); rst_n = 1;
    idle(2);

    // R3, R1: clocked byte writes to buffer 0, peeks on others
    scen = "R3 R1";
    for (int i = 0; i < 5; i++) wr(0, 16'hAB00 + 16'(i));
    peek(1); peek(0);
    rd(0); rd(0); peek(0);

    // R8: packet of the 5 written bytes, then a zero-length one
    scen = "R8";
    close(0); idle(1); close(0); idle(1);

    // R5: 16-bit buffer 1 byte order and two-byte removal
    scen = "R5";
    wr(1, 16'h2211); wr(1, 16'h4433); wr(1, 16'h6655);
    peek(1); rd(1); peek(1); rd(1);

    // R11: odd leftover byte in a 16-bit buffer
    scen = "R11";
    word_cfg[1] = 1'b0; wr(1, 16'hFF77); word_cfg[1] = 1'b1;
    peek(1); rd(1); peek(1); rd(1); peek(1);

    // R2: deselected strobes do nothing
    scen = "R2";
    cs_n = 1; oe = 1; wr_strb = 1; rd_strb = 1; pkt_end = 1; fifo_addr = 0; data_in = 16'h5A5A;
    repeat (3) tick();
    idle(1); peek(0);

    // R9: read of empty buffer 3 ignored
    scen = "R9";
    rd(3); rd(3); peek(3);

    // R3: mixed read and write on the same edge
    scen = "R3";
    cs_n = 0; oe = 1; fifo_addr = 0; wr_strb = 1; rd_strb = 1; data_in = 16'h00C3;
    repeat (4) tick();
    wr_strb = 0; rd_strb = 0; peek(0);

    // R6, R9: fill buffer 2 to 512 bytes, extra write dropped
    scen = "R6 R9";
    for (int i = 0; i < DEPTH + 2; i++) wr(2, 16'(i));
    peek(2); peek(2); rd(2); peek(2); peek(2);

    // R6: 16-bit write with one byte free dropped whole
    scen = "R6";
    for (int i = 0; i < DEPTH / 2 - 1; i++) wr(3, 16'(i * 3));
    word_cfg[3] = 1'b0; wr(3, 16'h0011); word_cfg[3] = 1'b1;
    wr(3, 16'hBEEF); peek(3); peek(3); close(3); idle(1);

    // R4: edge style, held strobes count once each
    scen = "R4";
    async_mode = 1; idle(4);
    for (int p = 0; p < 4; p++) begin
      cs_n = 0; oe = 0; fifo_addr = 0; data_in = 16'h0090 + 16'(p); wr_strb = 1;
      repeat (4) tick();
      wr_strb = 0; repeat (2) tick();
    end
    cs_n = 0; fifo_addr = 0; rd_strb = 1; oe = 1; repeat (5) tick();
    rd_strb = 0; repeat (3) tick();
    pkt_end = 1; repeat (3) tick(); pkt_end = 0; repeat (4) tick();
    cs_n = 1; wr_strb = 1; repeat (4) tick(); wr_strb = 0; idle(4);
    async_mode = 0; idle(4);
    peek(0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule